// File: doc/BRIEF.md
# System Clock Source Selector with Staged PLL Settings

This block picks the system clock source for a chip and divides it down to a system tick. Five sources are modelled as single-cycle enable ticks inside one clock domain: a fast internal RC oscillator, an external crystal oscillator, a slow internal RC oscillator, a real-time-clock oscillator and the PLL output. The ticks of the active source pass through an integer divider. The result is a clock-enable pulse, `sys_tick`, that downstream logic uses in place of a derived clock.

The PLL settings are an enable bit, a multiplier and a lock-delay count. They are written into staging registers and have no effect until software sets the commit bit in the control register. Commit copies the staged values into the active set and drops the lock flag. A counter then models the PLL settling time. The PLL can only drive the system tick while it reports lock. A request for the PLL while it is unlocked leaves the current source running. A commit while the PLL is running moves the system onto the fast internal oscillator until lock returns. After reset the PLL is off and the fast internal oscillator is active.

The register port is a plain single-cycle write strobe with a combinational read. There is no data stream, so no valid/ready handshake is used.

Top module: `sysclk_src_sel`

## Requirements
- R1: After reset the active source is 0, the lock flag is 0, the control word reads 0, the status word reads 0, the PLL enable and multiplier are 0, and the staged lock delay reads the parameter `DLY_RST` (default 4).
- R2: Writes to the staging words (address 1: bit 31 PLL enable, bits 9:0 multiplier; address 2: bits 15:0 lock delay) read back at once. They leave the active PLL enable and multiplier shown in status unchanged until a commit.
- R3: Writing the control word (address 0) with bit 31 set makes bit 31 read 1 for the next cycle only. At the following clock edge the staged settings are copied to the active set and bit 31 reads 0.
- R4: The apply edge clears the lock flag. If the applied enable is 1 and the applied delay is D, the lock flag reads 1 exactly D+1 cycles after the apply edge. If the applied enable is 0, the lock flag stays 0.
- R5: A request for the PLL (source code 4) while the lock flag is 0 keeps the previous source. The switch to the PLL happens one cycle after the lock flag first reads 1.
- R6: A commit while the PLL is the active source moves the active source to the fast internal oscillator (code 0) at the apply edge.
- R7: Source codes 0 to 3 (fast RC, crystal, slow RC, RTC) requested in control bits 2:0 take effect one cycle after the write. Codes 5 to 7 leave the active source unchanged.
- R8: With divisor N in control bits 15:8, `sys_tick` pulses once for every N ticks of the active source, one cycle after the N-th tick. A divisor of 0 acts as 1.
- R9: Ticks on sources other than the active one never produce `sys_tick`.
- R10: At the edge where the active source changes, the divide count restarts from zero and no `sys_tick` comes from that cycle.
- R11: Writes to the status word (address 3) have no effect. Status reads bit 0 lock flag, bit 1 active PLL enable, bits 6:4 active source and bits 25:16 active multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| src_tick | input | 5 | Enable ticks of the five sources, bit i is source code i |
| sys_tick | output | 1 | Divided system tick |
| active_src | output | 3 | Source code now in use |
| pll_locked | output | 1 | PLL lock flag |

## Verification
A commit can land while the PLL is already the active source. In that case the apply edge must clear the lock flag and pull the source back to the fast oscillator together, and the divider must restart at that same edge. The bench provokes this with the PLL running and locked, then recommits a shorter delay. It checks that the lock flag and the active source change on the same cycle. It also checks that the PLL is selected again exactly one cycle after lock. A scoreboard holds the expected cycle of every `sys_tick` and reports any missing or extra pulse across the source changes. A second pairing is a source switch that arrives while a divide count is part-way through. This is judged by the pulse position after the restart.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_W   = 3;

  localparam logic [SRC_W-1:0] SRC_HFRC = 3'd0;
  localparam logic [SRC_W-1:0] SRC_XTAL = 3'd1;
  localparam logic [SRC_W-1:0] SRC_LFRC = 3'd2;
  localparam logic [SRC_W-1:0] SRC_RTC  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_PLL  = 3'd4;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_PLLA = 2'd1;
  localparam logic [1:0] ADDR_PLLB = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTL_DIV_LSB  = 8;
  localparam int CTL_COMMIT   = 31;
  localparam int PLLA_EN      = 31;
  localparam int STAT_SRC_LSB = 4;
  localparam int STAT_MUL_LSB = 16;
endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int MUL_W = 10,
  parameter int DLY_W = 16,
  parameter logic [DLY_W-1:0] DLY_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             locked,
  input  logic [SRC_W-1:0] active_src,
  output logic [31:0]      rdata,
  output logic [SRC_W-1:0] src_req,
  output logic [DIV_W-1:0] div_val,
  output logic             apply,
  output logic [DLY_W-1:0] stg_dly,
  output logic             act_en
);
  logic             pend;
  logic             stg_en;
  logic [MUL_W-1:0] stg_mul;
  logic [MUL_W-1:0] act_mul;
  logic             wr_commit;

  assign wr_commit = we && (addr == ADDR_CTL) && wdata[CTL_COMMIT];
  assign apply     = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_req <= SRC_HFRC;
      div_val <= '0;
      pend    <= 1'b0;
      stg_en  <= 1'b0;
      stg_mul <= '0;
      stg_dly <= DLY_RST;
      act_en  <= 1'b0;
      act_mul <= '0;
    end else begin
      pend <= 1'b0;
      if (pend) begin
        act_en  <= stg_en;
        act_mul <= stg_mul;
      end
      if (we) begin
        case (addr)
          ADDR_CTL: begin
            src_req <= wdata[SRC_W-1:0];
            div_val <= wdata[CTL_DIV_LSB +: DIV_W];
            pend    <= wdata[CTL_COMMIT];
          end
          ADDR_PLLA: begin
            stg_en  <= wdata[PLLA_EN];
            stg_mul <= wdata[MUL_W-1:0];
          end
          ADDR_PLLB: stg_dly <= wdata[DLY_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTL: begin
        rdata[SRC_W-1:0]            = src_req;
        rdata[CTL_DIV_LSB +: DIV_W] = div_val;
        rdata[CTL_COMMIT]           = pend;
      end
      ADDR_PLLA: begin
        rdata[PLLA_EN]     = stg_en;
        rdata[MUL_W-1:0]   = stg_mul;
      end
      ADDR_PLLB: rdata[DLY_W-1:0] = stg_dly;
      default: begin
        rdata[0]                      = locked;
        rdata[1]                      = act_en;
        rdata[STAT_SRC_LSB +: SRC_W]  = active_src;
        rdata[STAT_MUL_LSB +: MUL_W]  = act_mul;
      end
    endcase
  end

  // R3: the commit flag lives for one cycle unless it is written again
  assert_commit_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wr_commit) |=> !pend);
  // R2: the active PLL settings move only on an apply edge
  assert_staged_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> ($stable(act_mul) && $stable(act_en)));
endmodule

// File: rtl/clksel_lock.sv
module clksel_lock #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [DLY_W-1:0] stg_dly,
  input  logic             act_en,
  output logic             locked
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      cnt    <= '0;
    end else if (apply) begin
      locked <= 1'b0;
      cnt    <= stg_dly;
    end else if (act_en && !locked) begin
      if (cnt == '0) locked <= 1'b1;
      else           cnt    <= cnt - 1'b1;
    end
  end

  // R4: an apply edge always leaves the PLL unlocked
  assert_lock_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !locked);
  // R4: a disabled PLL never reports lock
  assert_off_no_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> !locked);
endmodule

// File: rtl/clksel_mux.sv
module clksel_mux
  import clksel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   src_req,
  input  logic               apply,
  input  logic               locked,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [SRC_W-1:0]   active_src,
  output logic               sel_tick,
  output logic               switching
);
  logic [SRC_W-1:0] nxt_src;

  always_comb begin
    nxt_src = active_src;
    if (src_req < SRC_PLL) begin
      nxt_src = src_req;
    end else if (apply) begin
      if (active_src == SRC_PLL) nxt_src = SRC_HFRC;
    end else if (src_req == SRC_PLL && locked) begin
      nxt_src = SRC_PLL;
    end
  end

  assign switching = (nxt_src != active_src);

  always_ff @(posedge clk) begin
    if (!rst_n) active_src <= SRC_HFRC;
    else        active_src <= nxt_src;
  end

  always_comb begin
    case (active_src)
      SRC_HFRC: sel_tick = src_tick[0];
      SRC_XTAL: sel_tick = src_tick[1];
      SRC_LFRC: sel_tick = src_tick[2];
      SRC_RTC:  sel_tick = src_tick[3];
      SRC_PLL:  sel_tick = src_tick[4] && locked;
      default:  sel_tick = 1'b0;
    endcase
  end

  // R5: the PLL is never the active source without lock
  assert_pll_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_src == SRC_PLL) |-> locked);
  // R6: an apply while on the PLL falls back to the fast RC oscillator
  assert_apply_leave_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && active_src == SRC_PLL && src_req >= SRC_PLL) |=> (active_src == SRC_HFRC));
  // R7: reserved codes do not move the source
  assert_bad_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req > SRC_PLL && !apply) |=> $stable(active_src));
endmodule

// File: rtl/clksel_div.sv
module clksel_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sel_tick,
  input  logic             switching,
  output logic             sys_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last_cnt;

  assign last_cnt = (div_val == '0) ? '0 : div_val - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sys_tick <= 1'b0;
    end else begin
      sys_tick <= 1'b0;
      if (switching) begin
        cnt <= '0;
      end else if (sel_tick) begin
        if (cnt >= last_cnt) begin
          cnt      <= '0;
          sys_tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: every output pulse follows a tick of the active source
  assert_tick_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |-> $past(sel_tick));
  // R8: divisors 0 and 1 pass each tick straight through
  assert_div1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!switching && sel_tick && div_val <= 1) |=> sys_tick);
  // R10: a source change swallows that cycle's tick
  assert_switch_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    switching |=> !sys_tick);
endmodule

// File: rtl/sysclk_src_sel.sv
module sysclk_src_sel
  import clksel_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int MUL_W = 10,
  parameter int DLY_W = 16,
  parameter logic [DLY_W-1:0] DLY_RST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               sys_tick,
  output logic [SRC_W-1:0]   active_src,
  output logic               pll_locked
);
  logic [SRC_W-1:0] src_req;
  logic [DIV_W-1:0] div_val;
  logic             apply;
  logic [DLY_W-1:0] stg_dly;
  logic             act_en;
  logic             sel_tick;
  logic             switching;

  clksel_regs #(.DIV_W(DIV_W), .MUL_W(MUL_W), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .locked(pll_locked), .active_src(active_src), .rdata(reg_rdata),
    .src_req(src_req), .div_val(div_val), .apply(apply),
    .stg_dly(stg_dly), .act_en(act_en)
  );

  clksel_lock #(.DLY_W(DLY_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .apply(apply), .stg_dly(stg_dly),
    .act_en(act_en), .locked(pll_locked)
  );

  clksel_mux u_mux (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .apply(apply),
    .locked(pll_locked), .src_tick(src_tick), .active_src(active_src),
    .sel_tick(sel_tick), .switching(switching)
  );

  clksel_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .sel_tick(sel_tick),
    .switching(switching), .sys_tick(sys_tick)
  );
endmodule

// File: tb/sysclk_src_sel_tb.sv
module sysclk_src_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [4:0]  src_tick = 5'd0;
  logic        sys_tick;
  logic [2:0]  active_src;
  logic        pll_locked;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  int exp_src = 0;
  int eff_div = 1;
  int exp_cnt = 0;
  logic [31:0] rv;
  logic [31:0] s0;

  always #2 clk = ~clk;

  sysclk_src_sel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
    .sys_tick(sys_tick), .active_src(active_src), .pll_locked(pll_locked)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] stat(input logic lk, input logic en,
                                       input logic [2:0] s, input logic [9:0] m);
    stat = {6'd0, m, 9'd0, s, 2'd0, en, lk};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [4:0] m);
    src_tick = m;
    if (m[exp_src]) begin
      exp_cnt++;
      if (exp_cnt >= eff_div) begin
        exp_q.push_back(cyc + 1);
        exp_cnt = 0;
      end
    end
    @(posedge clk); @(negedge clk);
    src_tick = 5'd0;
  endtask

  // scoreboard monitor: R8, R9, R10
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL R8 missing sys_tick actual none expected cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (sys_tick) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) void'(exp_q.pop_front());
        else begin
          errors++;
          $display("FAIL R9 unexpected sys_tick actual cycle %0d expected %0d", cyc,
                   exp_q.size() > 0 ? exp_q[0] : -1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1 src", {29'd0, active_src}, 32'd0);
    chk("R1 lock", {31'd0, pll_locked}, 32'd0);
    rd(2'd0, rv); chk("R1 ctl", rv, 32'd0);
    rd(2'd3, rv); chk("R1 stat", rv, 32'd0);
    rd(2'd2, rv); chk("R1 delay", rv, 32'd4);
    // R8 divisor 0 acts as 1, R9 other ticks ignored
    pulse(5'b00001); idle(1); pulse(5'b00001); pulse(5'b00001);
    pulse(5'b11110); idle(2);
    // R8 divide by 3
    wr(2'd0, 32'h0000_0300); eff_div = 3;
    pulse(5'b00001); pulse(5'b00010); pulse(5'b00001); pulse(5'b00001);
    pulse(5'b00001); idle(1); pulse(5'b00001); pulse(5'b00001); idle(2);
    // R7 select crystal
    wr(2'd0, 32'h0000_0101); @(negedge clk);
    chk("R7 src xtal", {29'd0, active_src}, 32'd1);
    exp_src = 1; eff_div = 1; exp_cnt = 0;
    pulse(5'b00010); pulse(5'b00001); idle(1);
    // R7 reserved code ignored
    wr(2'd0, 32'h0000_0106); idle(2);
    chk("R7 reserved", {29'd0, active_src}, 32'd1);
    pulse(5'b00010); idle(1);
    // R11 status write ignored
    rd(2'd3, s0); wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, rv);
    chk("R11 stat", rv, s0);
    // R2 staged settings
    wr(2'd1, 32'h8000_0155); wr(2'd2, 32'd3);
    rd(2'd3, rv); chk("R2 stat", rv, stat(1'b0, 1'b0, 3'd1, 10'd0));
    rd(2'd1, rv); chk("R2 plla", rv, 32'h8000_0155);
    // R5 PLL request while unlocked
    wr(2'd0, 32'h0000_0104); idle(4);
    chk("R5 hold", {29'd0, active_src}, 32'd1);
    pulse(5'b00010); idle(1);
    // R3 / R4 commit with delay 3
    wr(2'd0, 32'h8000_0204); eff_div = 2; exp_cnt = 0;
    rd(2'd0, rv); chk("R3 pending", rv, 32'h8000_0204);
    @(negedge clk);
    rd(2'd0, rv); chk("R3 cleared", rv, 32'h0000_0204);
    rd(2'd3, rv); chk("R3 applied", rv, stat(1'b0, 1'b1, 3'd1, 10'h155));
    idle(3); chk("R4 not yet", {31'd0, pll_locked}, 32'd0);
    @(negedge clk); chk("R4 locked", {31'd0, pll_locked}, 32'd1);
    chk("R5 before", {29'd0, active_src}, 32'd1);
    @(negedge clk); chk("R5 pll", {29'd0, active_src}, 32'd4);
    exp_src = 4; exp_cnt = 0;
    pulse(5'b10000); pulse(5'b10000); pulse(5'b01111); pulse(5'b10000);
    pulse(5'b10000); idle(2);
    // R6 recommit while on PLL, delay 2
    wr(2'd2, 32'd2); wr(2'd0, 32'h8000_0204);
    chk("R6 still pll", {29'd0, active_src}, 32'd4);
    @(negedge clk);
    chk("R6 fallback", {29'd0, active_src}, 32'd0);
    chk("R6 unlock", {31'd0, pll_locked}, 32'd0);
    idle(2); chk("R4 d2 wait", {31'd0, pll_locked}, 32'd0);
    @(negedge clk); chk("R4 d2 lock", {31'd0, pll_locked}, 32'd1);
    @(negedge clk); chk("R5 back", {29'd0, active_src}, 32'd4);
    exp_cnt = 0;
    pulse(5'b10000); pulse(5'b10000); idle(2);
    // R4 PLL disabled stays unlocked
    wr(2'd1, 32'h0000_0155); wr(2'd0, 32'h8000_0004);
    @(negedge clk); chk("R6 off fallback", {29'd0, active_src}, 32'd0);
    idle(6);
    chk("R4 off", {31'd0, pll_locked}, 32'd0);
    rd(2'd3, rv); chk("R4 stat", rv, stat(1'b0, 1'b0, 3'd0, 10'h155));
    exp_src = 0; eff_div = 1; exp_cnt = 0;
    pulse(5'b00001); pulse(5'b10000); idle(1);
    // R10 switch mid-count
    wr(2'd0, 32'h0000_0301); @(negedge clk);
    exp_src = 1; eff_div = 3; exp_cnt = 0;
    pulse(5'b00010); pulse(5'b00010);
    wr(2'd0, 32'h0000_0300); @(negedge clk);
    exp_src = 0; exp_cnt = 0;
    pulse(5'b00001); pulse(5'b00001); pulse(5'b00001); idle(3);
    chk("R10 queue empty", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule